// File: doc/BRIEF.md
# Indirect Register Access Bridge

This block gives a byte-wide host bus access to a bank of up to 64 core registers that are not mapped into the host's address space. The host sees only two locations: a control register, which holds the core-register address, an auto-read enable and a read-busy flag, and a data register. A write to the data register goes straight through to the addressed core register as a one-cycle write strobe. A read from a core register is posted. The host sets the busy flag, and the bridge then fetches the byte over a fixed number of cycles. When busy drops, the data register holds the fetched byte.

For block reads, the host can set the auto-read enable. Each time the host consumes the data register while no fetch is in flight, the bridge starts the next fetch from the same address. This lets the host stream a FIFO-like core register without rewriting the control register between bytes. A host write to the control register takes effect only while no fetch is in flight.

Top module: `ind_reg_bridge`

## Requirements
- R1: After reset the control register reads 0x00 (busy clear, auto-read off, address 0) and `core_rd` is low.
- R2: A control write while idle stores write-data bits 5:0 as the address and bit 6 as the auto-read enable. If bit 7 is 0, no fetch starts.
- R3: A control write with bit 7 set while idle starts a fetch. Busy (`core_rd`) is then high for exactly RD_LAT cycles with `core_addr` held. On the edge that clears busy, the data register takes `core_rdata`.
- R4: With auto-read off, a host read of the data register (`hst_sel`=1) returns the latched byte and starts no fetch.
- R5: With auto-read on and busy clear, a host read of the data register returns the latched byte and starts a new fetch of the same address. The address field is unchanged.
- R6: A host write to the data register while idle drives `core_wr` high for that one cycle only, with `core_addr` equal to the address field and `core_wdata` equal to the written byte.
- R7: A host write to the data register while busy is ignored: `core_wr` stays low and the core register keeps its value.
- R8: A host read of the data register while busy returns the previously latched byte and does not start or extend a fetch.
- R9: A control write while busy is ignored. Address, auto-read and busy keep their values, and the fetch ends on its original schedule.
- R10: Reading the control register (`hst_sel`=0) returns busy in bit 7, auto-read in bit 6 and the address in bits 5:0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hst_sel | input | 1 | Host location select: 0 control, 1 data |
| hst_wr | input | 1 | Host write strobe |
| hst_rd | input | 1 | Host read strobe |
| hst_wdata | input | 8 | Host write byte |
| hst_rdata | output | 8 | Selected location's content |
| core_addr | output | 6 | Core register address |
| core_rd | output | 1 | Fetch in flight; core must present `core_rdata` for `core_addr` |
| core_rdata | input | 8 | Core read byte |
| core_wr | output | 1 | Core write strobe |
| core_wdata | output | 8 | Core write byte |

## Verification
Host reads and the core write strobe are combinational, so their results are due in the same cycle as the stimulus. The bench drives on a falling edge and samples 1 ns later, before the rising edge. Busy rises on the first rising edge after a fetch-starting access and falls RD_LAT edges later. The bench counts the falling edges at which `core_rd` is high after the access and compares that count with RD_LAT, or with RD_LAT minus the cycles already spent when a second access lands mid-fetch. The data register is read only after that count ends, so the value checked is the one latched on the clearing edge.

// File: rtl/ind_reg_bridge.sv
module ind_reg_bridge #(
  parameter int DATA_W = 8,
  parameter int RD_LAT = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hst_sel,
  input  logic              hst_wr,
  input  logic              hst_rd,
  input  logic [DATA_W-1:0] hst_wdata,
  output logic [DATA_W-1:0] hst_rdata,
  output logic [DATA_W-3:0] core_addr,
  output logic              core_rd,
  input  logic [DATA_W-1:0] core_rdata,
  output logic              core_wr,
  output logic [DATA_W-1:0] core_wdata
);
  localparam int ADDR_W = DATA_W - 2;
  localparam int CW = $clog2(RD_LAT + 1);

  logic              busy_q, auto_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] data_q;
  logic [CW-1:0]     cnt_q;

  wire ctl_wr = hst_wr & ~hst_sel;
  wire dat_wr = hst_wr & hst_sel;
  wire dat_rd = hst_rd & hst_sel & ~hst_wr;
  wire start  = ~busy_q & ((ctl_wr & hst_wdata[DATA_W-1]) | (dat_rd & auto_q));
  wire done   = busy_q & (cnt_q == CW'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      auto_q <= 1'b0;
      addr_q <= '0;
      data_q <= '0;
      cnt_q  <= '0;
    end else begin
      if (ctl_wr && !busy_q) begin
        addr_q <= hst_wdata[ADDR_W-1:0];
        auto_q <= hst_wdata[DATA_W-2];
      end
      if (start) begin
        busy_q <= 1'b1;
        cnt_q  <= CW'(RD_LAT);
      end else if (busy_q) begin
        cnt_q <= cnt_q - CW'(1);
        if (done) begin
          busy_q <= 1'b0;
          data_q <= core_rdata;
        end
      end
    end
  end

  assign core_addr  = addr_q;
  assign core_rd    = busy_q;
  assign core_wr    = dat_wr & ~busy_q;
  assign core_wdata = hst_wdata;
  assign hst_rdata  = hst_sel ? data_q : {busy_q, auto_q, addr_q};
endmodule

module ind_reg_bridge_chk #(
  parameter int DATA_W = 8,
  parameter int RD_LAT = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              hst_sel,
  input logic              hst_wr,
  input logic              hst_rd,
  input logic              auto_q,
  input logic [DATA_W-1:0] data_q,
  input logic [DATA_W-3:0] core_addr,
  input logic              core_rd,
  input logic [DATA_W-1:0] core_rdata
);
  logic [15:0] run_q;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) run_q <= '0;
    else run_q <= core_rd ? run_q + 16'd1 : 16'd0;

  assert_busy_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
    core_rd |-> run_q < 16'(RD_LAT));
  assert_busy_length_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(core_rd) |-> $past(run_q) == 16'(RD_LAT - 1));
  assert_fetch_latch_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(core_rd) |-> data_q == $past(core_rdata));
  assert_addr_held_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(core_rd) && core_rd) |-> $stable(core_addr));
  assert_auto_same_addr_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(core_rd) && !$past(hst_wr)) |-> $stable(core_addr));
  assert_no_plain_fetch_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (hst_rd && hst_sel && !hst_wr && !auto_q && !core_rd) |=> !core_rd);
endmodule

bind ind_reg_bridge ind_reg_bridge_chk #(.DATA_W(DATA_W), .RD_LAT(RD_LAT)) u_chk (
  .clk(clk), .rst_n(rst_n), .hst_sel(hst_sel), .hst_wr(hst_wr), .hst_rd(hst_rd),
  .auto_q(auto_q), .data_q(data_q), .core_addr(core_addr), .core_rd(core_rd),
  .core_rdata(core_rdata)
);

// File: tb/ind_reg_bridge_bench.sv
`timescale 1ns/1ps
module ind_reg_bridge_bench;
  localparam int LAT = 3;
  logic clk = 0, rst_n = 0;
  logic hst_sel = 0, hst_wr = 0, hst_rd = 0;
  logic [7:0] hst_wdata = 0, hst_rdata, core_rdata, core_wdata;
  logic [5:0] core_addr;
  logic core_rd, core_wr;
  logic [7:0] mem [64];
  int total = 0, bad = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  ind_reg_bridge #(.DATA_W(8), .RD_LAT(LAT)) u_ind_reg_bridge (
    .clk(clk), .rst_n(rst_n), .hst_sel(hst_sel), .hst_wr(hst_wr), .hst_rd(hst_rd),
    .hst_wdata(hst_wdata), .hst_rdata(hst_rdata), .core_addr(core_addr),
    .core_rd(core_rd), .core_rdata(core_rdata), .core_wr(core_wr),
    .core_wdata(core_wdata));

  assign core_rdata = mem[core_addr];
  always @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      for (int i = 0; i < 64; i++) mem[i] <= 8'(i * 7 + 3);
    end else if (core_wr) mem[core_addr] <= core_wdata;

  task automatic chk(string req, int got, int exp);
    total++;
    if (got != exp) begin
      bad++;
      $display("FAIL %s: got 0x%0h expected 0x%0h", req, got, exp);
    end
  endtask

  task automatic wr(bit sel, logic [7:0] d);
    hst_sel = sel; hst_wdata = d; hst_wr = 1;
    @(negedge clk);
    hst_wr = 0; hst_sel = 0;
  endtask

  task automatic rd(bit sel, output logic [7:0] v);
    hst_sel = sel; hst_rd = 1;
    #1 v = hst_rdata;
    @(negedge clk);
    hst_rd = 0; hst_sel = 0;
  endtask

  task automatic peek_ctl(output logic [7:0] v);
    hst_sel = 0;
    #1 v = hst_rdata;
  endtask

  task automatic wait_idle(output int n);
    n = 0;
    while (core_rd && n < 100) begin n++; @(negedge clk); end
  endtask

  task automatic t_reset();
    logic [7:0] v;
    peek_ctl(v);
    chk("R1 ctl", v, 8'h00);
    chk("R1 core_rd", core_rd, 0);
  endtask

  task automatic t_ctl_fields();
    logic [7:0] v;
    @(negedge clk); wr(0, 8'h25);
    peek_ctl(v);
    chk("R2 addr", v, 8'h25);
    chk("R2 no fetch", core_rd, 0);
    @(negedge clk); wr(0, 8'h49);
    peek_ctl(v);
    chk("R10 layout", v, 8'h49);
    @(negedge clk); wr(0, 8'h09);
  endtask

  task automatic t_plain_read();
    logic [7:0] v; int n;
    @(negedge clk); wr(0, 8'h85);
    wait_idle(n);
    chk("R3 latency", n, LAT);
    peek_ctl(v);
    chk("R3 busy clear", v, 8'h05);
    rd(1, v);
    chk("R3 data", v, 8'd38);
    chk("R4 no fetch", core_rd, 0);
    rd(1, v);
    chk("R4 data kept", v, 8'd38);
  endtask

  task automatic t_data_write();
    logic [7:0] v; int n;
    @(negedge clk); wr(0, 8'h14);
    hst_sel = 1; hst_wdata = 8'h3C; hst_wr = 1;
    #1;
    chk("R6 strobe", core_wr, 1);
    chk("R6 addr", core_addr, 6'd20);
    chk("R6 wdata", core_wdata, 8'h3C);
    @(negedge clk); hst_wr = 0; hst_sel = 0;
    #1 chk("R6 one cycle", core_wr, 0);
    @(negedge clk); wr(0, 8'h94);
    wait_idle(n);
    rd(1, v);
    chk("R6 readback", v, 8'h3C);
  endtask

  task automatic t_write_busy();
    logic [7:0] v; int n;
    @(negedge clk); wr(0, 8'h94);
    hst_sel = 1; hst_wdata = 8'h11; hst_wr = 1;
    #1 chk("R7 no strobe", core_wr, 0);
    @(negedge clk); hst_wr = 0; hst_sel = 0;
    wait_idle(n);
    wr(0, 8'h94);
    wait_idle(n);
    rd(1, v);
    chk("R7 core kept", v, 8'h3C);
  endtask

  task automatic t_auto();
    logic [7:0] v; int n;
    @(negedge clk); wr(0, 8'hCC);
    wait_idle(n);
    wr(1, 8'hA5);
    rd(1, v);
    chk("R5 old byte", v, 8'd87);
    chk("R5 refetch", core_rd, 1);
    wait_idle(n);
    chk("R5 latency", n, LAT);
    peek_ctl(v);
    chk("R5 addr kept", v, 8'h4C);
    rd(1, v);
    chk("R5 new byte", v, 8'hA5);
    wait_idle(n);
  endtask

  task automatic t_read_busy();
    logic [7:0] v; int n;
    @(negedge clk); wr(0, 8'hC3);
    wait_idle(n);
    wr(1, 8'h77);
    rd(1, v);
    rd(1, v);
    chk("R8 prev byte", v, 8'd24);
    wait_idle(n);
    chk("R8 not extended", n, LAT - 1);
    rd(1, v);
    chk("R8 fetched", v, 8'h77);
    wait_idle(n);
    wr(0, 8'h03);
  endtask

  task automatic t_ctl_busy();
    logic [7:0] v; int n;
    @(negedge clk); wr(0, 8'h87);
    wr(0, 8'hC9);
    wait_idle(n);
    chk("R9 schedule", n, LAT - 1);
    peek_ctl(v);
    chk("R9 ctl kept", v, 8'h07);
    rd(1, v);
    chk("R9 data", v, 8'h34);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_ctl_fields();
    t_plain_read();
    t_data_write();
    t_write_busy();
    t_auto();
    t_read_busy();
    t_ctl_busy();
    repeat (2) @(negedge clk);
    if (!finished) begin
      finished = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      total++; bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule